// File: doc/BRIEF.md
# Two-Channel Chained Breakpoint Unit

This unit sits beside a simple in-order processor whose branches have one delay slot. Each cycle it sees the instruction being fetched, with its address, whether it is a delayed branch or a delay-slot instruction, whether a branch is taken and where it goes. It also sees the operand access being made, with address, direction and data. Two comparator channels, called A and B, each watch either the instruction address or the operand bus. When a programmed condition holds, the unit raises a one-cycle break request together with the program counter that execution should resume from.

The resume address depends on when the break is taken. A channel can break before the matched instruction runs or after it completes, and delay slots change which address is correct. In chained mode, channel A only arms channel B, and a break happens only on a B event that follows an A event. After a break, a busy flag blocks further requests until software clears it through the write port.

Top module: `seq_brk_ctrl`

## Requirements
- R1: While reset is held and after it is released, brk_req is 0 and saved_pc is 0. Chaining is disarmed and the busy flag is clear.
- R2: Register index {c,field} (c = cfg_idx[3], 0 for A and 1 for B) selects the field: 0 compare address, 1 address mask, 2 compare data, 3 data mask, 4 control. Control bit 0 enables the channel and bit 1 selects operand (1) or fetch (2'b0 in that bit). A fetch channel matches when ins_valid is high and ins_pc equals the compare address on every bit whose mask bit is 0. A disabled channel never matches.
- R3: An operand channel matches on op_valid when the address compare holds and the direction is permitted: control bit 2 allows reads and bit 3 allows writes. When control bit 4 is set, op_data must also equal the compare data on every bit whose data-mask bit is 0.
- R4: With chaining off (index 7, bit 0 = 0), a match on either channel produces a break.
- R5: With chaining on, an A match never breaks and a B match breaks only if an A match happened in an earlier cycle. B alone never breaks. A B event six or more instructions after the A event always breaks.
- R6: The armed state clears in the cycle the break is issued and whenever chaining is off.
- R7: Control bit 5 = 0 selects a break before execution. saved_pc is the matched instruction's address, or the owning delayed branch's address when the matched instruction is a delay slot.
- R8: Control bit 5 = 1 selects a break after execution. For an ordinary instruction, saved_pc is its address plus INSN_BYTES.
- R9: After-execution matches on a delay slot break at once. Matches on a delayed branch are held until the next valid instruction (its slot) and break in the cycle after it. In both cases saved_pc is the branch destination: the target when taken, otherwise the branch address plus twice INSN_BYTES.
- R10: An operand break saves the address that follows the instruction valid in the same cycle, or follows the most recent valid instruction when none is presented.
- R11: brk_req rises in the cycle after the triggering input and lasts one cycle. saved_pc holds its value until the next break.
- R12: Issuing a break sets a busy flag that blocks every further request. Writing 1 to bit 0 of index 15 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index {channel, field} |
| cfg_wdata | input | DW | Register write data |
| ins_valid | input | 1 | An instruction is presented this cycle |
| ins_pc | input | AW | Instruction address |
| ins_dbr | input | 1 | Instruction is a delayed branch |
| ins_slot | input | 1 | Instruction sits in a delay slot |
| ins_taken | input | 1 | Delayed branch is taken |
| ins_target | input | AW | Delayed branch target |
| op_valid | input | 1 | An operand access is presented this cycle |
| op_addr | input | AW | Operand address |
| op_wr | input | 1 | Operand access is a write |
| op_data | input | DW | Operand data |
| brk_req | output | 1 | Break request pulse |
| saved_pc | output | AW | Resume address for the break |

## Verification
The hardest case to reach from the ports is a deferred after-execution break on a delayed branch. It needs the branch presented with the match, then the slot in the next valid cycle, and the request shows up only after the slot. Breaks on delay slots need the same setup, since the owning branch must come first. Each table row therefore places a non-matching delayed branch ahead of the matched address when a slot is wanted, and always follows with the next instruction. Chained tests arm channel A and then present at least six filler instructions before the B access, so the bench does not depend on the best-effort window.

// File: rtl/seq_brk_pkg.sv
`timescale 1ns/1ps
package seq_brk_pkg;
  localparam int NCH   = 2;
  localparam int IDX_W = 4;

  // field codes inside a channel's register window
  localparam logic [2:0] FLD_ADDR  = 3'd0;
  localparam logic [2:0] FLD_AMASK = 3'd1;
  localparam logic [2:0] FLD_DATA  = 3'd2;
  localparam logic [2:0] FLD_DMASK = 3'd3;
  localparam logic [2:0] FLD_CTRL  = 3'd4;
  localparam logic [2:0] FLD_GLOB  = 3'd7;  // window 0: chain mode, window 1: busy clear

  typedef struct packed {
    logic after;  // bit 5
    logic den;    // bit 4
    logic wr_ok;  // bit 3
    logic rd_ok;  // bit 2
    logic opsel;  // bit 1
    logic en;     // bit 0
  } chan_ctrl_t;

  typedef enum logic [2:0] {
    K_NONE, K_BEFORE, K_AFTER, K_DEFER, K_OPER
  } brk_kind_t;
endpackage

// File: rtl/brk_cfg_regs.sv
`timescale 1ns/1ps
module brk_cfg_regs
  import seq_brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [DW-1:0]        cfg_wdata,
  output logic [AW-1:0]        ch_addr  [NCH],
  output logic [AW-1:0]        ch_amask [NCH],
  output logic [DW-1:0]        ch_data  [NCH],
  output logic [DW-1:0]        ch_dmask [NCH],
  output chan_ctrl_t           ch_ctrl  [NCH],
  output logic                 seq_on,
  output logic                 bip_clr
);
  localparam int CTRL_W = $bits(chan_ctrl_t);

  logic [2:0] fld;
  logic       win;
  assign fld = cfg_idx[2:0];
  assign win = cfg_idx[IDX_W-1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic CSEL = 1'(c);
    logic hit_win;
    assign hit_win = cfg_we && (win == CSEL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_addr[c]  <= '0;
        ch_amask[c] <= '0;
        ch_data[c]  <= '0;
        ch_dmask[c] <= '0;
        ch_ctrl[c]  <= '0;
      end else if (hit_win) begin
        case (fld)
          FLD_ADDR:  ch_addr[c]  <= cfg_wdata[AW-1:0];
          FLD_AMASK: ch_amask[c] <= cfg_wdata[AW-1:0];
          FLD_DATA:  ch_data[c]  <= cfg_wdata;
          FLD_DMASK: ch_dmask[c] <= cfg_wdata;
          FLD_CTRL:  ch_ctrl[c]  <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   seq_on <= 1'b0;
    else if (cfg_we && !win && fld == FLD_GLOB)   seq_on <= cfg_wdata[0];
  end

  assign bip_clr = cfg_we && win && (fld == FLD_GLOB) && cfg_wdata[0];
endmodule

// File: rtl/brk_chan_match.sv
`timescale 1ns/1ps
module brk_chan_match
  import seq_brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  chan_ctrl_t      ctrl,
  input  logic [AW-1:0]   cmp_addr,
  input  logic [AW-1:0]   cmp_amask,
  input  logic [DW-1:0]   cmp_data,
  input  logic [DW-1:0]   cmp_dmask,
  input  logic            ins_valid,
  input  logic [AW-1:0]   ins_pc,
  input  logic            ins_dbr,
  input  logic            op_valid,
  input  logic [AW-1:0]   op_addr,
  input  logic            op_wr,
  input  logic [DW-1:0]   op_data,
  output logic            hit,
  output brk_kind_t       kind
);
  // mask bit 1 means "do not compare this bit"
  function automatic logic addr_eq(input logic [AW-1:0] a, input logic [AW-1:0] ref_a,
                                   input logic [AW-1:0] m);
    return ((a ^ ref_a) & ~m) == '0;
  endfunction

  function automatic logic data_eq(input logic [DW-1:0] d, input logic [DW-1:0] ref_d,
                                   input logic [DW-1:0] m);
    return ((d ^ ref_d) & ~m) == '0;
  endfunction

  logic fetch_hit, oper_hit, dir_ok, val_ok;

  assign dir_ok    = op_wr ? ctrl.wr_ok : ctrl.rd_ok;
  assign val_ok    = !ctrl.den || data_eq(op_data, cmp_data, cmp_dmask);
  assign fetch_hit = ctrl.en && !ctrl.opsel && ins_valid && addr_eq(ins_pc, cmp_addr, cmp_amask);
  assign oper_hit  = ctrl.en && ctrl.opsel && op_valid && dir_ok && val_ok
                     && addr_eq(op_addr, cmp_addr, cmp_amask);
  assign hit       = fetch_hit || oper_hit;

  always_comb begin
    if (!hit)             kind = K_NONE;
    else if (ctrl.opsel)  kind = K_OPER;
    else if (!ctrl.after) kind = K_BEFORE;
    else if (ins_dbr)     kind = K_DEFER;
    else                  kind = K_AFTER;
  end
endmodule

// File: rtl/brk_pc_track.sv
`timescale 1ns/1ps
module brk_pc_track #(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  input  logic [AW-1:0]   ins_pc,
  input  logic            ins_dbr,
  input  logic            ins_slot,
  input  logic            ins_taken,
  input  logic [AW-1:0]   ins_target,
  output logic [AW-1:0]   pc_before,
  output logic [AW-1:0]   pc_after,
  output logic [AW-1:0]   pc_oper,
  output logic [AW-1:0]   pc_pend
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + STEP;
  endfunction

  function automatic logic [AW-1:0] branch_dest(input logic [AW-1:0] a, input logic tk,
                                                input logic [AW-1:0] t);
    return tk ? t : a + (STEP << 1);
  endfunction

  logic [AW-1:0] dbr_pc_q, dbr_dest_q, last_next_q, cur_next;

  assign cur_next = ins_slot ? dbr_dest_q : step_addr(ins_pc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbr_pc_q    <= '0;
      dbr_dest_q  <= '0;
      last_next_q <= '0;
    end else if (ins_valid) begin
      last_next_q <= cur_next;
      if (ins_dbr) begin
        dbr_pc_q   <= ins_pc;
        dbr_dest_q <= branch_dest(ins_pc, ins_taken, ins_target);
      end
    end
  end

  assign pc_before = ins_slot ? dbr_pc_q : ins_pc;
  assign pc_after  = cur_next;
  assign pc_oper   = ins_valid ? cur_next : last_next_q;
  assign pc_pend   = dbr_dest_q;
endmodule

// File: rtl/seq_brk_ctrl.sv
`timescale 1ns/1ps
module seq_brk_ctrl
  import seq_brk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int INSN_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_idx,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             ins_valid,
  input  logic [AW-1:0]    ins_pc,
  input  logic             ins_dbr,
  input  logic             ins_slot,
  input  logic             ins_taken,
  input  logic [AW-1:0]    ins_target,
  input  logic             op_valid,
  input  logic [AW-1:0]    op_addr,
  input  logic             op_wr,
  input  logic [DW-1:0]    op_data,
  output logic             brk_req,
  output logic [AW-1:0]    saved_pc
);
  localparam int CH_A = 0;
  localparam int CH_B = 1;

  logic [AW-1:0] ch_addr  [NCH];
  logic [AW-1:0] ch_amask [NCH];
  logic [DW-1:0] ch_data  [NCH];
  logic [DW-1:0] ch_dmask [NCH];
  chan_ctrl_t    ch_ctrl  [NCH];
  logic          seq_on, bip_clr;

  brk_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .ch_addr(ch_addr), .ch_amask(ch_amask), .ch_data(ch_data), .ch_dmask(ch_dmask),
    .ch_ctrl(ch_ctrl), .seq_on(seq_on), .bip_clr(bip_clr)
  );

  logic [NCH-1:0] hit;
  brk_kind_t      kind [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_match
    brk_chan_match #(.AW(AW), .DW(DW)) u_match (
      .ctrl(ch_ctrl[c]), .cmp_addr(ch_addr[c]), .cmp_amask(ch_amask[c]),
      .cmp_data(ch_data[c]), .cmp_dmask(ch_dmask[c]),
      .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_dbr(ins_dbr),
      .op_valid(op_valid), .op_addr(op_addr), .op_wr(op_wr), .op_data(op_data),
      .hit(hit[c]), .kind(kind[c])
    );
  end

  logic [AW-1:0] pc_before, pc_after, pc_oper, pc_pend;

  brk_pc_track #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_pc (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_dbr(ins_dbr),
    .ins_slot(ins_slot), .ins_taken(ins_taken), .ins_target(ins_target),
    .pc_before(pc_before), .pc_after(pc_after), .pc_oper(pc_oper), .pc_pend(pc_pend)
  );

  // named internal events, brought out for the checker
  logic           armed_q, pend_q, bip_q;
  logic [NCH-1:0] fire, f_before, f_after, f_defer, f_oper;
  logic           any_before, any_after, any_defer, any_oper, pend_due;
  logic           issue_now, brk_d;
  logic [AW-1:0]  sel_pc;

  // channel A breaks alone only when chaining is off; B needs arming in chain mode
  assign fire[CH_A] = hit[CH_A] && !seq_on;
  assign fire[CH_B] = hit[CH_B] && (!seq_on || armed_q);

  for (genvar c = 0; c < NCH; c++) begin : g_kind
    assign f_before[c] = fire[c] && (kind[c] == K_BEFORE);
    assign f_after[c]  = fire[c] && (kind[c] == K_AFTER);
    assign f_defer[c]  = fire[c] && (kind[c] == K_DEFER);
    assign f_oper[c]   = fire[c] && (kind[c] == K_OPER);
  end

  assign any_before = |f_before;
  assign any_after  = |f_after;
  assign any_defer  = |f_defer;
  assign any_oper   = |f_oper;
  assign pend_due   = pend_q && ins_valid;
  assign issue_now  = any_before || pend_due || any_after || any_oper;
  assign brk_d      = issue_now && !bip_q;

  // earlier break point wins when several fire together
  always_comb begin
    if (any_before)     sel_pc = pc_before;
    else if (pend_due)  sel_pc = pc_pend;
    else if (any_after) sel_pc = pc_after;
    else                sel_pc = pc_oper;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req  <= 1'b0;
      saved_pc <= '0;
      armed_q  <= 1'b0;
      pend_q   <= 1'b0;
      bip_q    <= 1'b0;
    end else begin
      brk_req <= brk_d;
      if (brk_d) saved_pc <= sel_pc;

      if (!seq_on || brk_d)   armed_q <= 1'b0;
      else if (hit[CH_A])     armed_q <= 1'b1;

      if (any_defer && !issue_now && !bip_q) pend_q <= 1'b1;
      else if (ins_valid)                    pend_q <= 1'b0;

      if (brk_d)        bip_q <= 1'b1;
      else if (bip_clr) bip_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_brk_chk.sv
`timescale 1ns/1ps
module seq_brk_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          brk_req,
  input logic [AW-1:0] saved_pc,
  input logic          armed_q,
  input logic          pend_q,
  input logic          bip_q,
  input logic          seq_on,
  input logic          ins_valid
);
  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  p_saved_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req |-> $stable(saved_pc));

  p_busy_masks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bip_q |=> !brk_req);

  p_busy_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> bip_q);

  p_armed_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !armed_q);

  p_chain_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_on |=> !armed_q);

  p_chain_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(seq_on) && !$past(pend_q)) |-> $past(armed_q));

  p_pend_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ins_valid) |=> !pend_q);
endmodule

bind seq_brk_ctrl seq_brk_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .saved_pc(saved_pc),
  .armed_q(armed_q), .pend_q(pend_q), .bip_q(bip_q), .seq_on(seq_on),
  .ins_valid(ins_valid)
);

// File: tb/seq_brk_ctrl_test.sv
`timescale 1ns/1ps
module seq_brk_ctrl_test;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          cfg_we;
  logic [3:0]    cfg_idx;
  logic [DW-1:0] cfg_wdata;
  logic          ins_valid, ins_dbr, ins_slot, ins_taken;
  logic [AW-1:0] ins_pc, ins_target;
  logic          op_valid, op_wr;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          brk_req;
  logic [AW-1:0] saved_pc;

  seq_brk_ctrl #(.AW(AW), .DW(DW), .INSN_BYTES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_dbr(ins_dbr), .ins_slot(ins_slot),
    .ins_taken(ins_taken), .ins_target(ins_target), .op_valid(op_valid), .op_addr(op_addr),
    .op_wr(op_wr), .op_data(op_data), .brk_req(brk_req), .saved_pc(saved_pc)
  );

  int            n_chk = 0;
  int            n_fail = 0;
  logic          got_brk;
  logic [AW-1:0] got_pc;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic iv, input logic [31:0] pc, input logic dbr, input logic slot,
                     input logic tk, input logic [31:0] tgt, input logic ov,
                     input logic [31:0] oa, input logic ow, input logic [31:0] od);
    ins_valid = iv; ins_pc = pc; ins_dbr = dbr; ins_slot = slot; ins_taken = tk;
    ins_target = tgt; op_valid = ov; op_addr = oa; op_wr = ow; op_data = od;
    @(posedge clk); #1;
    got_brk = brk_req; got_pc = saved_pc;
    ins_valid = 1'b0; op_valid = 1'b0; ins_dbr = 1'b0; ins_slot = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] pc, input logic dbr, input logic slot,
                       input logic tk, input logic [31:0] tgt);
    cyc(1'b1, pc, dbr, slot, tk, tgt, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic oper(input logic iv, input logic [31:0] pc, input logic [31:0] oa,
                      input logic ow, input logic [31:0] od);
    cyc(iv, pc, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, oa, ow, od);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Channel A watches 0x200. A non-matching delayed branch at 0x1FE (target 0x400)
  // precedes the match when a delay slot is wanted.
  typedef struct packed {
    logic        after;
    logic        en;
    logic        pre;
    logic        dbr;
    logic        taken;
    logic [15:0] pc;
    logic [1:0]  when;   // 0 none, 1 right after match, 2 after the following instruction
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0200, 2'd1, 16'h0200},  // R7 plain
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0200, 2'd1, 16'h0202},  // R8
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0200, 2'd1, 16'h01FE},  // R7 slot
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0200, 2'd1, 16'h0400},  // R9 slot taken
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0200, 2'd1, 16'h0202},  // R9 slot not taken
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0200, 2'd2, 16'h0800},  // R9 branch taken
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0200, 2'd2, 16'h0204},  // R9 branch not taken
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0200, 2'd1, 16'h0200},  // R7 on branch
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0204, 2'd0, 16'h0000},  // R2 miss
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0200, 2'd0, 16'h0000}   // R2 disabled
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 2, 7: return "R7";
      1:       return "R8";
      8, 9:    return "R2";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    ins_valid = 1'b0; ins_pc = '0; ins_dbr = 1'b0; ins_slot = 1'b0; ins_taken = 1'b0;
    ins_target = '0; op_valid = 1'b0; op_addr = '0; op_wr = 1'b0; op_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 brk in reset", {31'b0, brk_req}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 brk after reset", {31'b0, brk_req}, 32'h0);
    check("R1 saved_pc after reset", saved_pc, 32'h0);

    // table of fetch-side cases on channel A
    wr(4'd0, 32'h200);
    wr(4'd1, 32'h0);
    for (int i = 0; i < NV; i++) begin
      logic          b1, b2;
      logic [31:0]   p1, p2;
      wr(4'd4, {26'b0, VT[i].after, 4'b0, VT[i].en});
      wr(4'd15, 32'h1);
      if (VT[i].pre) fetch(32'h1FE, 1'b1, 1'b0, VT[i].taken, 32'h400);
      else           fetch(32'h100, 1'b0, 1'b0, 1'b0, 32'h0);
      fetch({16'h0, VT[i].pc}, VT[i].dbr, VT[i].pre, VT[i].taken, 32'h800);
      b1 = got_brk; p1 = got_pc;
      fetch({16'h0, VT[i].pc} + 32'h2, 1'b0, VT[i].dbr, 1'b0, 32'h0);
      b2 = got_brk; p2 = got_pc;
      case (VT[i].when)
        2'd1: begin
          check($sformatf("%s row %0d brk", tag_of(i), i), {31'b0, b1}, 32'h1);
          check($sformatf("%s row %0d pc", tag_of(i), i), p1, {16'h0, VT[i].exp});
          check($sformatf("R11 row %0d one-cycle pulse", i), {31'b0, b2}, 32'h0);
        end
        2'd2: begin
          check($sformatf("%s row %0d no early brk", tag_of(i), i), {31'b0, b1}, 32'h0);
          check($sformatf("%s row %0d late brk", tag_of(i), i), {31'b0, b2}, 32'h1);
          check($sformatf("%s row %0d pc", tag_of(i), i), p2, {16'h0, VT[i].exp});
        end
        default: begin
          check($sformatf("%s row %0d no brk", tag_of(i), i), {31'b0, b1}, 32'h0);
          check($sformatf("%s row %0d no late brk", tag_of(i), i), {31'b0, b2}, 32'h0);
        end
      endcase
      cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    end

    // R2 address mask: bits 7:4 ignored
    wr(4'd1, 32'hF0);
    wr(4'd4, 32'h1);
    wr(4'd15, 32'h1);
    fetch(32'h2A0, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R2 masked hit brk", {31'b0, got_brk}, 32'h1);
    check("R2 masked hit pc", got_pc, 32'h2A0);
    // R12 busy flag blocks
    fetch(32'h200, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R12 masked while busy", {31'b0, got_brk}, 32'h0);
    check("R11 saved_pc held", got_pc, 32'h2A0);
    wr(4'd15, 32'h1);
    fetch(32'h300, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R2 unmasked bit differs", {31'b0, got_brk}, 32'h0);
    fetch(32'h2F0, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R12 brk after clear", {31'b0, got_brk}, 32'h1);
    check("R12 pc after clear", got_pc, 32'h2F0);

    // chained setup: A fetch 0x300 before, B operand write 0x9000 data 0x55
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h300);
    wr(4'd4, 32'h01);
    wr(4'd8, 32'h9000);
    wr(4'd9, 32'h0);
    wr(4'd10, 32'h55);
    wr(4'd11, 32'h0);
    wr(4'd12, 32'h1B);
    wr(4'd7, 32'h1);
    wr(4'd15, 32'h1);
    oper(1'b1, 32'h500, 32'h9000, 1'b1, 32'h55);
    check("R5 B alone no brk", {31'b0, got_brk}, 32'h0);
    fetch(32'h300, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R5 A in chain no brk", {31'b0, got_brk}, 32'h0);
    for (int k = 0; k < 6; k++) fetch(32'h600 + 32'(2 * k), 1'b0, 1'b0, 1'b0, 32'h0);
    oper(1'b1, 32'h700, 32'h9000, 1'b1, 32'h56);
    check("R3 data mismatch", {31'b0, got_brk}, 32'h0);
    oper(1'b1, 32'h700, 32'h9000, 1'b0, 32'h55);
    check("R3 read not allowed", {31'b0, got_brk}, 32'h0);
    oper(1'b1, 32'h700, 32'h9010, 1'b1, 32'h55);
    check("R3 address mismatch", {31'b0, got_brk}, 32'h0);
    oper(1'b1, 32'h700, 32'h9000, 1'b1, 32'h55);
    check("R5 chained brk", {31'b0, got_brk}, 32'h1);
    check("R10 pc with same-cycle insn", got_pc, 32'h702);
    cyc(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    check("R11 pulse ends", {31'b0, got_brk}, 32'h0);
    check("R11 pc stays", got_pc, 32'h702);
    wr(4'd15, 32'h1);
    oper(1'b1, 32'h720, 32'h9000, 1'b1, 32'h55);
    check("R6 disarmed after brk", {31'b0, got_brk}, 32'h0);
    fetch(32'h300, 1'b0, 1'b0, 1'b0, 32'h0);
    wr(4'd7, 32'h0);
    wr(4'd7, 32'h1);
    oper(1'b1, 32'h720, 32'h9000, 1'b1, 32'h55);
    check("R6 disarmed by chain off", {31'b0, got_brk}, 32'h0);
    fetch(32'h300, 1'b0, 1'b0, 1'b0, 32'h0);
    for (int k = 0; k < 6; k++) fetch(32'h700 + 32'(2 * k), 1'b0, 1'b0, 1'b0, 32'h0);
    oper(1'b0, 32'h0, 32'h9000, 1'b1, 32'h55);
    check("R5 chained brk op only", {31'b0, got_brk}, 32'h1);
    check("R10 pc from last insn", got_pc, 32'h70C);

    // R4 chain off: B alone breaks
    wr(4'd7, 32'h0);
    wr(4'd15, 32'h1);
    oper(1'b1, 32'h800, 32'h9000, 1'b1, 32'h55);
    check("R4 B alone brk", {31'b0, got_brk}, 32'h1);
    check("R4 pc", got_pc, 32'h802);
    // R3 data mask ignores low byte
    wr(4'd11, 32'hFF);
    wr(4'd15, 32'h1);
    oper(1'b1, 32'h810, 32'h9000, 1'b1, 32'hAA);
    check("R3 data mask brk", {31'b0, got_brk}, 32'h1);
    check("R3 data mask pc", got_pc, 32'h812);

    summary();
    $finish;
  end
endmodule